// File: doc/BRIEF.md
# Pseudo-SRAM Write Sequencer with Deep Power-Down Control

This block sits on the host side of an asynchronous pseudo-SRAM and turns single-cycle write requests into correctly timed memory write cycles. A request carries an address, a 16-bit word and two byte-enable bits. The sequencer first pulls chip-select low and holds the address for a setup interval. It then lowers write-enable and the selected byte strobes for the pulse interval. At the end it raises chip-select and write-enable together and keeps the address and data steady through a recovery interval. The setup, pulse and recovery lengths are parameters counted in system clocks.

The same sequencer handles the memory's deep power-down. A sleep command drops the secondary chip-enable and waits out a fixed suspend time, about half a microsecond. A wake command raises the enable again and blocks all access for a wake-up time of two hundred microseconds. Both times are derived from a clock-frequency parameter. The block starts in the wake-up state after reset, so the power-up delay always passes before the first write reaches the memory. A write requested while the sequencer is busy is held in a single slot and issued as soon as the sequencer is free.

Top module: `psram_wr_ctrl`

## Requirements
- R1: During reset and afterwards, busy is high, chip-select, write-enable and both byte strobes are high (inactive), the secondary enable is high and the data output-enable is low. Busy stays high for exactly WAKE clocks after reset is released, where WAKE = 200 × CLK_MHZ.
- R2: Write-enable is low only while chip-select is low. Chip-select falls exactly SETUP_CYC clocks before write-enable falls.
- R3: Write-enable stays low for exactly PULSE_CYC clocks.
- R4: The upper strobe is low during the pulse exactly when byte-enable bit 1 is set. The lower strobe is low exactly when bit 0 is set. Neither strobe is low outside the pulse.
- R5: Chip-select and write-enable rise on the same clock. The address and data seen at the memory during the cycle are the ones supplied with the request, and they do not change while chip-select is low.
- R6: After chip-select rises, the address does not change for RECOV_CYC clocks. In a back-to-back write, the next address appears exactly RECOV_CYC clocks after the previous chip-select rise.
- R7: The data output-enable rises on the clock where write-enable falls. It stays high for PULSE_CYC + RECOV_CYC clocks, covering the pulse and the data-hold interval, and is low at all other times.
- R8: Busy is high whenever the sequencer is not idle. A write requested while busy is held in one slot and issued later with the address, data and byte enables it was requested with.
- R9: A sleep command accepted when idle drives the secondary enable low for SUSP clocks of suspend plus the time spent powered down, where SUSP = ceil(CLK_MHZ/2). A wake command is obeyed only once the block is powered down. A wake command given while idle or during the suspend has no effect.
- R10: While the secondary enable is low, chip-select stays high and requested writes wait. After a wake command, the first chip-select fall comes exactly WAKE + 1 clocks after the secondary enable rises.
- R11: When a write request and a sleep command arrive in the same idle cycle, the write is performed and the sleep command is dropped. A sleep command given while busy is also dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrReq | input | 1 | One-cycle write request |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 16 | Write data word |
| wrBe | input | 2 | Byte enables, bit 1 upper byte, bit 0 lower byte |
| sleepReq | input | 1 | One-cycle deep power-down command |
| wakeReq | input | 1 | Leave deep power-down command |
| busy | output | 1 | Sequencer not idle |
| memCsN | output | 1 | Memory chip-select, active low |
| memCe2 | output | 1 | Memory secondary enable, low selects power-down |
| memWeN | output | 1 | Memory write-enable, active low |
| memUbN | output | 1 | Upper byte strobe, active low |
| memLbN | output | 1 | Lower byte strobe, active low |
| memAddr | output | ADDR_W | Memory address bus |
| memDout | output | 16 | Memory data bus value |
| memDoe | output | 1 | Data bus output-enable, low releases the lines |

## Verification
A write request and a sleep command can both land in one idle cycle. Only one of them can be taken. The bench provokes this by raising both inputs on the same clock. It judges the result by checking that a complete write cycle appears at the memory pins with the requested address and data, and that the secondary enable stays high with busy returning low. A related collision, a write held back during power-down and a wake command, is judged by counting the clocks from the secondary enable rising to the first chip-select fall.

// File: rtl/psram_pkg.sv
package psram_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WRITE,
    ST_RECOVER,
    ST_SUSPEND,
    ST_POWERDOWN,
    ST_WAKE
  } seqState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;     // capture a new active write
    logic usePend;  // active write comes from the held slot
    logic stash;    // store the request inputs in the held slot
    logic csOn;
    logic weOn;
    logic doeOn;
    logic ce2On;
  } ctlStrobe_t;

endpackage

// File: rtl/psram_seq_ctrl.sv
module psram_seq_ctrl
  import psram_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int RECOV_CYC = 2,
  parameter int CLK_MHZ   = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrReq,
  input  logic       sleepReq,
  input  logic       wakeReq,
  output logic       busy,
  output ctlStrobe_t strb
);

  localparam int SETUP_N = (SETUP_CYC < 1) ? 1 : SETUP_CYC;
  localparam int PULSE_N = (PULSE_CYC < 1) ? 1 : PULSE_CYC;
  localparam int RECOV_N = (RECOV_CYC < 1) ? 1 : RECOV_CYC;
  localparam int SUSP_N  = (CLK_MHZ < 2) ? 1 : (CLK_MHZ + 1) / 2;
  localparam int WAKE_N  = (CLK_MHZ < 1) ? 1 : 200 * CLK_MHZ;
  localparam int MAX_A   = (SETUP_N > PULSE_N) ? SETUP_N : PULSE_N;
  localparam int MAX_B   = (RECOV_N > SUSP_N) ? RECOV_N : SUSP_N;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_N   = (MAX_C > WAKE_N) ? MAX_C : WAKE_N;
  localparam int CNT_W   = $clog2(MAX_N + 1);

  seqState_t        state, nxtState;
  logic [CNT_W-1:0] cnt, nxtCnt;
  logic             pendValid, nxtPend;
  logic             doLoad, fromPend, doStash;
  logic             cntDone;

  assign cntDone = (cnt == '0);

  always_comb begin
    nxtState = state;
    nxtCnt   = cntDone ? cnt : cnt - 1'b1;
    doLoad   = 1'b0;
    fromPend = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (pendValid || wrReq) begin
          doLoad   = 1'b1;
          fromPend = pendValid;
          nxtState = ST_SETUP;
          nxtCnt   = CNT_W'(SETUP_N - 1);
        end else if (sleepReq) begin
          nxtState = ST_SUSPEND;
          nxtCnt   = CNT_W'(SUSP_N - 1);
        end
      end
      ST_SETUP: if (cntDone) begin
        nxtState = ST_WRITE;
        nxtCnt   = CNT_W'(PULSE_N - 1);
      end
      ST_WRITE: if (cntDone) begin
        nxtState = ST_RECOVER;
        nxtCnt   = CNT_W'(RECOV_N - 1);
      end
      ST_RECOVER: if (cntDone) nxtState = ST_IDLE;
      ST_SUSPEND: if (cntDone) nxtState = ST_POWERDOWN;
      ST_POWERDOWN: if (wakeReq) begin
        nxtState = ST_WAKE;
        nxtCnt   = CNT_W'(WAKE_N - 1);
      end
      ST_WAKE: if (cntDone) nxtState = ST_IDLE;
      default: nxtState = ST_IDLE;
    endcase
  end

  // a request that is not launched directly goes to the held slot
  assign doStash = wrReq && !((state == ST_IDLE) && !pendValid);

  always_comb begin
    nxtPend = pendValid;
    if (doStash) nxtPend = 1'b1;
    else if (doLoad && fromPend) nxtPend = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_WAKE;
      cnt       <= CNT_W'(WAKE_N - 1);
      pendValid <= 1'b0;
    end else begin
      state     <= nxtState;
      cnt       <= nxtCnt;
      pendValid <= nxtPend;
    end
  end

  assign busy         = (state != ST_IDLE);
  assign strb.load    = doLoad;
  assign strb.usePend = fromPend;
  assign strb.stash   = doStash;
  assign strb.csOn    = (state == ST_SETUP) || (state == ST_WRITE);
  assign strb.weOn    = (state == ST_WRITE);
  assign strb.doeOn   = (state == ST_WRITE) || (state == ST_RECOVER);
  assign strb.ce2On   = !((state == ST_SUSPEND) || (state == ST_POWERDOWN));

endmodule

// File: rtl/psram_wr_dpath.sv
module psram_wr_dpath
  import psram_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [1:0]        wrBe,
  output logic              memCsN,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memUbN,
  output logic              memLbN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memDout,
  output logic              memDoe
);

  logic [ADDR_W-1:0] pendAddr, actAddr;
  logic [WORD_W-1:0] pendData, actData;
  logic [1:0]        pendBe, actBe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendAddr <= '0;
      pendData <= '0;
      pendBe   <= '0;
      actAddr  <= '0;
      actData  <= '0;
      actBe    <= '0;
    end else begin
      if (strb.stash) begin
        pendAddr <= wrAddr;
        pendData <= wrData;
        pendBe   <= wrBe;
      end
      if (strb.load) begin
        actAddr <= strb.usePend ? pendAddr : wrAddr;
        actData <= strb.usePend ? pendData : wrData;
        actBe   <= strb.usePend ? pendBe : wrBe;
      end
    end
  end

  // pins are registered so the memory sees glitch-free edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      memCsN <= 1'b1;
      memWeN <= 1'b1;
      memUbN <= 1'b1;
      memLbN <= 1'b1;
      memCe2 <= 1'b1;
      memDoe <= 1'b0;
    end else begin
      memCsN <= !strb.csOn;
      memWeN <= !strb.weOn;
      memUbN <= !(strb.weOn && actBe[1]);
      memLbN <= !(strb.weOn && actBe[0]);
      memCe2 <= strb.ce2On;
      memDoe <= strb.doeOn;
    end
  end

  assign memAddr = actAddr;
  assign memDout = actData;

endmodule

// File: rtl/psram_wr_ctrl.sv
module psram_wr_ctrl
  import psram_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int RECOV_CYC = 2,
  parameter int CLK_MHZ   = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  input  logic [1:0]        wrBe,
  input  logic              sleepReq,
  input  logic              wakeReq,
  output logic              busy,
  output logic              memCsN,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memUbN,
  output logic              memLbN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memDout,
  output logic              memDoe
);

  ctlStrobe_t strb;

  psram_seq_ctrl #(
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .RECOV_CYC(RECOV_CYC),
    .CLK_MHZ  (CLK_MHZ)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrReq   (wrReq),
    .sleepReq(sleepReq),
    .wakeReq (wakeReq),
    .busy    (busy),
    .strb    (strb)
  );

  psram_wr_dpath #(
    .ADDR_W(ADDR_W)
  ) u_dpath (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .wrBe   (wrBe),
    .memCsN (memCsN),
    .memCe2 (memCe2),
    .memWeN (memWeN),
    .memUbN (memUbN),
    .memLbN (memLbN),
    .memAddr(memAddr),
    .memDout(memDout),
    .memDoe (memDoe)
  );

endmodule

// File: rtl/psram_wr_chk.sv
module psram_wr_chk #(
  parameter int ADDR_W    = 20,
  parameter int RECOV_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              memCsN,
  input logic              memCe2,
  input logic              memWeN,
  input logic              memUbN,
  input logic              memLbN,
  input logic [ADDR_W-1:0] memAddr,
  input logic [15:0]       memDout,
  input logic              memDoe
);

  localparam int RECOV_N = (RECOV_CYC < 1) ? 1 : RECOV_CYC;
  localparam int HW      = $clog2(RECOV_N + 1);

  logic          prevCs;
  logic [HW-1:0] holdLeft;

  // counts the recovery window after chip-select rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevCs   <= 1'b1;
      holdLeft <= '0;
    end else begin
      prevCs <= memCsN;
      if (memCsN && !prevCs) holdLeft <= HW'(RECOV_N - 1);
      else if (holdLeft != '0) holdLeft <= holdLeft - 1'b1;
    end
  end

  a_r2_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !memWeN |-> !memCsN);

  a_r4_strobes_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!memUbN || !memLbN) |-> !memWeN);

  a_r5_end_together: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memWeN) |-> $rose(memCsN));

  a_r5_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!memCsN && $past(!memCsN)) |-> $stable(memAddr));

  a_r6_recovery_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (holdLeft != '0) |-> $stable(memAddr));

  a_r7_doe_at_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(memWeN) |-> memDoe);

  a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (memDoe && $past(memDoe)) |-> $stable(memDout));

  a_r8_busy_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !memCsN |-> busy);

  a_r10_no_access_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    !memCe2 |-> (memCsN && !memDoe));

endmodule

bind psram_wr_ctrl psram_wr_chk #(
  .ADDR_W   (ADDR_W),
  .RECOV_CYC(RECOV_CYC)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .memCsN (memCsN),
  .memCe2 (memCe2),
  .memWeN (memWeN),
  .memUbN (memUbN),
  .memLbN (memLbN),
  .memAddr(memAddr),
  .memDout(memDout),
  .memDoe (memDoe)
);

// File: tb/tb_psram_wr_ctrl.sv
module tb_psram_wr_ctrl;

  localparam int AW     = 8;
  localparam int SETUP  = 2;
  localparam int PULSE  = 3;
  localparam int RECOV  = 2;
  localparam int MHZ    = 8;
  localparam int SUSP   = (MHZ + 1) / 2;
  localparam int WAKE   = 200 * MHZ;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wrReq = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [15:0]   wrData = '0;
  logic [1:0]    wrBe = '0;
  logic          sleepReq = 1'b0;
  logic          wakeReq = 1'b0;
  logic          busy, memCsN, memCe2, memWeN, memUbN, memLbN, memDoe;
  logic [AW-1:0] memAddr;
  logic [15:0]   memDout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  psram_wr_ctrl #(
    .ADDR_W(AW), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE),
    .RECOV_CYC(RECOV), .CLK_MHZ(MHZ)
  ) dut (
    .clk(clk), .rst_n(rst_n), .wrReq(wrReq), .wrAddr(wrAddr),
    .wrData(wrData), .wrBe(wrBe), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .busy(busy), .memCsN(memCsN), .memCe2(memCe2), .memWeN(memWeN),
    .memUbN(memUbN), .memLbN(memLbN), .memAddr(memAddr),
    .memDout(memDout), .memDoe(memDoe)
  );

  // ---------------- pin monitor ----------------
  int          sIdx = 0;
  int          nObs = 0;
  int          csFallIdx = 0, weFallIdx = 0, endIdx = 0, doeRiseIdx = 0;
  logic        prevCsN = 1'b1, prevWeN = 1'b1, prevDoe = 1'b0;
  logic [AW-1:0] prevAddr = '0, startAddr = '0;
  int          setupNow = 0;
  logic        ubNow = 1'b0, lbNow = 1'b0, doeAtFall = 1'b0;
  logic [15:0] dataNow = '0;
  logic [AW-1:0] obsAddr [64];
  logic [15:0] obsData [64];
  logic        obsUb [64], obsLb [64], obsTogether [64], obsDoeAt [64], obsSteady [64];
  int          obsSetup [64], obsPulse [64], obsDoeLen [64], obsGap [64];

  always @(negedge clk) begin
    if (rst_n) begin
      sIdx = sIdx + 1;
      if (!memCsN && prevCsN) begin
        csFallIdx = sIdx;
        startAddr = memAddr;
      end
      if (!memWeN && prevWeN) begin
        setupNow  = sIdx - csFallIdx;
        weFallIdx = sIdx;
        ubNow     = !memUbN;
        lbNow     = !memLbN;
        doeAtFall = memDoe;
        dataNow   = memDout;
      end
      if (memWeN && !prevWeN && nObs < 64) begin
        obsAddr[nObs]     = memAddr;
        obsData[nObs]     = dataNow;
        obsUb[nObs]       = ubNow;
        obsLb[nObs]       = lbNow;
        obsSetup[nObs]    = setupNow;
        obsPulse[nObs]    = sIdx - weFallIdx;
        obsTogether[nObs] = memCsN && !prevCsN;
        obsDoeAt[nObs]    = doeAtFall;
        obsSteady[nObs]   = (memAddr == startAddr) && (memDout == dataNow);
        obsDoeLen[nObs]   = -1;
        obsGap[nObs]      = -1;
        endIdx = sIdx;
        nObs = nObs + 1;
      end
      if (memDoe && !prevDoe) doeRiseIdx = sIdx;
      if (!memDoe && prevDoe && nObs > 0) obsDoeLen[nObs-1] = sIdx - doeRiseIdx;
      if (memAddr != prevAddr && nObs > 0 && obsGap[nObs-1] < 0)
        obsGap[nObs-1] = sIdx - endIdx;
      prevCsN  = memCsN;
      prevWeN  = memWeN;
      prevDoe  = memDoe;
      prevAddr = memAddr;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitIdle();
    int quiet = 0;
    for (int i = 0; i < 20000 && quiet < 3; i++) begin
      @(negedge clk);
      quiet = busy ? 0 : quiet + 1;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic issueWrite(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    wrAddr = a; wrData = d; wrBe = be; wrReq = 1'b1;
    @(negedge clk);
    wrReq = 1'b0;
  endtask

  task automatic checkObs(input int i, input logic [AW-1:0] a, input logic [15:0] d,
                          input logic [1:0] be, input bit full);
    check(i < nObs, "R5 write observed", nObs, i + 1);
    if (i < nObs) begin
      check(obsSetup[i] == SETUP, "R2 cs-to-we setup", obsSetup[i], SETUP);
      check(obsPulse[i] == PULSE, "R3 pulse width", obsPulse[i], PULSE);
      check(obsUb[i] == be[1], "R4 upper strobe", int'(obsUb[i]), int'(be[1]));
      check(obsLb[i] == be[0], "R4 lower strobe", int'(obsLb[i]), int'(be[0]));
      check(obsTogether[i], "R5 cs and we rise together", int'(obsTogether[i]), 1);
      check(obsAddr[i] == a, "R5 address", int'(obsAddr[i]), int'(a));
      check(obsData[i] == d, "R5 data", int'(obsData[i]), int'(d));
      check(obsSteady[i], "R5 bus steady", int'(obsSteady[i]), 1);
      check(obsDoeAt[i], "R7 doe at pulse start", int'(obsDoeAt[i]), 1);
      if (full)
        check(obsDoeLen[i] == PULSE + RECOV, "R7 doe length", obsDoeLen[i], PULSE + RECOV);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  // ---------------- stimulus ----------------
  initial begin
    int cnt;
    int base;
    repeat (3) @(negedge clk);
    // R1 reset values
    check(busy == 1'b1, "R1 busy in reset", int'(busy), 1);
    check(memCsN && memWeN, "R1 cs/we idle", int'(memCsN & memWeN), 1);
    check(memUbN && memLbN, "R1 strobes idle", int'(memUbN & memLbN), 1);
    check(memCe2 == 1'b1, "R1 ce2 high", int'(memCe2), 1);
    check(memDoe == 1'b0, "R1 doe low", int'(memDoe), 0);
    rst_n = 1'b1;
    cnt = 0;
    for (int i = 0; i < WAKE + 10; i++) begin
      @(negedge clk);
      if (busy) cnt++;
      else break;
    end
    check(cnt == WAKE - 1, "R1 wake after reset", cnt, WAKE - 1);
    check(nObs == 0 && memCsN, "R1 no access during wake", nObs, 0);

    // sweep of byte enables and bus patterns
    for (int be = 0; be < 4; be++) begin
      for (int k = 0; k < 4; k++) begin
        logic [AW-1:0] a;
        logic [15:0] d;
        a = AW'(k * 53 + be * 17 + 5);
        d = 16'((k * 4099) ^ (be * 16'h1111) ^ 16'h5A00);
        base = nObs;
        issueWrite(a, d, 2'(be));
        waitIdle();
        checkObs(base, a, d, 2'(be), 1'b1);
      end
    end

    // R6, R8 back-to-back with held request
    base = nObs;
    @(negedge clk);
    wrAddr = 8'h11; wrData = 16'h1234; wrBe = 2'b11; wrReq = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
    wrAddr = 8'hE2; wrData = 16'hBEEF; wrBe = 2'b10;
    @(negedge clk);
    wrReq = 1'b0; wrAddr = 8'h00; wrData = 16'h0000; wrBe = 2'b00;
    waitIdle();
    checkObs(base, 8'h11, 16'h1234, 2'b11, 1'b1);
    checkObs(base + 1, 8'hE2, 16'hBEEF, 2'b10, 1'b1);
    if (base < nObs)
      check(obsGap[base] == RECOV, "R6 back-to-back recovery", obsGap[base], RECOV);

    // R11 write and sleep in the same idle cycle
    base = nObs;
    @(negedge clk);
    wrAddr = 8'h3C; wrData = 16'hC3C3; wrBe = 2'b01; wrReq = 1'b1; sleepReq = 1'b1;
    @(negedge clk);
    wrReq = 1'b0; sleepReq = 1'b0;
    waitIdle();
    checkObs(base, 8'h3C, 16'hC3C3, 2'b01, 1'b1);
    check(memCe2 == 1'b1 && !busy, "R11 sleep dropped on collision", int'(memCe2), 1);

    // R11 sleep while busy
    base = nObs;
    issueWrite(8'h77, 16'h0F0F, 2'b11);
    @(negedge clk);
    sleepReq = 1'b1;
    @(negedge clk);
    sleepReq = 1'b0;
    waitIdle();
    check(memCe2 == 1'b1 && !busy, "R11 sleep dropped while busy", int'(memCe2), 1);

    // R9 wake ignored when idle
    @(negedge clk);
    wakeReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0;
    @(negedge clk);
    check(!busy && memCe2, "R9 wake ignored in idle", int'(busy), 0);

    // R9 wake ignored during suspend, R10 held write and wake time
    @(negedge clk);
    sleepReq = 1'b1;
    @(negedge clk);
    sleepReq = 1'b0; wakeReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0;
    repeat (SUSP + 6) @(negedge clk);
    check(memCe2 == 1'b0 && busy, "R9 wake ignored in suspend", int'(memCe2), 0);
    base = nObs;
    issueWrite(8'h5A, 16'hA55A, 2'b11);
    repeat (10) @(negedge clk);
    check(nObs == base && memCsN, "R10 write waits while asleep", nObs, base);
    @(negedge clk);
    wakeReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0;
    for (int i = 0; i < 10 && !memCe2; i++) @(negedge clk);
    check(memCe2 == 1'b1, "R9 wake obeyed when asleep", int'(memCe2), 1);
    cnt = 0;
    for (int i = 0; i < WAKE + 20 && memCsN; i++) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == WAKE + 1, "R10 wake time before access", cnt, WAKE + 1);
    waitIdle();
    checkObs(base, 8'h5A, 16'hA55A, 2'b11, 1'b1);

    // R9 suspend length with wake held
    @(negedge clk);
    sleepReq = 1'b1; wakeReq = 1'b1;
    @(negedge clk);
    sleepReq = 1'b0;
    for (int i = 0; i < 10 && memCe2; i++) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < SUSP + 20 && !memCe2; i++) begin
      cnt++;
      @(negedge clk);
    end
    wakeReq = 1'b0;
    check(cnt == SUSP + 1, "R9 suspend length", cnt, SUSP + 1);
    waitIdle();
    check(!busy && memCe2, "R9 back to idle after wake", int'(busy), 0);

    finishRun();
  end

endmodule